// File: doc/BRIEF.md
# Sequential Serial Read Output Engine

This block is the read path of a three-wire serial memory slave. Once an upstream decoder has recognised a read opcode, the engine collects the word address from the data-in line one bit per serial-clock rising edge. On the next rising edge it drives a single zero bit, and then streams the addressed 16-bit word most significant bit first. While the host keeps clocking, it continues into the following words with no gap. The address wraps from the top word to word 0, so one command can dump the whole array.

The serial clock is sampled in the system clock domain through a two-stage sampler. Every action happens on the system clock edge that follows a detected serial-clock rising edge. The array is a small register file with a synchronous read port and a preload write port. The engine owns the word address counter and the output shift register. Data and output enable are brought out separately, and a tri-state pin is formed from them.

Top module: `srd_read_engine`

## Requirements
- R1: After reset, and with select low, the output enable `do_oe_o` is 0 and `do_dat_o` is 0.
- R2: With select high and the engine idle, a serial-clock rising edge with `rd_cmd_i` high starts an address phase. The next RX_BITS rising edges shift `di_i` in, most significant first. RX_BITS equals ADDR_W, except that with ADDR_W = 7 it is 8: the first bit received is a pad bit and has no effect on the address.
- R3: The rising edge after the last address bit drives a 0 on `do_dat_o` and raises `do_oe_o`. This happens exactly once per command.
- R4: Each following rising edge drives one bit of the addressed word, bit 15 first and bit 0 last. The output settles within two system clocks of the edge.
- R5: The rising edge after bit 0 of a word drives bit 15 of the word at the next higher address, with no further zero bit.
- R6: Continuing past the highest address (all ones) resumes at address 0.
- R7: `do_oe_o` is 0 whenever select is low, and also during idle and the address phase. `do_o` is high impedance whenever `do_oe_o` is 0. Dropping select aborts the read; a later command starts again with its zero bit.
- R8: The outputs change only on a detected serial-clock rising edge. With the serial clock held still, `do_dat_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled by clk |
| di_i | input | 1 | Serial data in, address bits |
| rd_cmd_i | input | 1 | Read opcode recognised by the decoder |
| wr_en_i | input | 1 | Array preload write strobe |
| wr_addr_i | input | ADDR_W | Array preload address |
| wr_data_i | input | WORD_W | Array preload data |
| do_o | output | 1 | Tri-state serial data out |
| do_oe_o | output | 1 | Output enable of do_o |
| do_dat_o | output | 1 | Data value behind do_o |

## Verification
The table-driven part of the bench reads from a low address, from the middle of the array, and from just below the top. These show single-word framing, chaining across a word boundary, and roll-over to word 0 respectively. Each array word holds a distinct computed pattern, so a wrong address, a wrong bit order or an extra zero bit shows up as a data mismatch. Directed cases then cover the following: the pad bit sent as both 0 and 1, which must select the same word; a long pause with the serial clock held still in the middle of a word; and select dropped mid-word followed by a fresh command.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } rd_phase_e;

  // number of serial bits carrying the address: the 7-bit variant adds a pad bit
  function automatic int unsigned rx_len(input int unsigned aw);
    return (aw == 7) ? aw + 1 : aw;
  endfunction

  // next word address, wrapping within an aw-bit space
  function automatic logic [15:0] wrap_inc(input logic [15:0] a, input int unsigned aw);
    logic [15:0] mask;
    mask = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & mask;
  endfunction

endpackage

// File: rtl/srd_edge.sv
module srd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_i,
  output logic rise_o
);
  logic [1:0] sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 2'b00;
    else        sk_q <= {sk_q[0], sk_i};
  end

  assign rise_o = sk_q[0] & ~sk_q[1];

  // a detected edge lasts one system clock only
  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/srd_wordmem.sv
module srd_wordmem #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) cells[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= cells[rd_addr_i];
  end

endmodule

// File: rtl/srd_shifter.sv
module srd_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              dummy_i,
  input  logic              bit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dout_o,
  output logic              reload_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign reload_o = bit_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; dout_o <= 1'b0;
    end else if (clr_i) begin
      sh_q <= '0; cnt_q <= '0; dout_o <= 1'b0;
    end else if (dummy_i) begin
      dout_o <= 1'b0;
      sh_q   <= word_i;
      cnt_q  <= '0;
    end else if (bit_i) begin
      dout_o <= sh_q[WORD_W-1];
      if (reload_o) begin
        sh_q  <= word_i;
        cnt_q <= '0;
      end else begin
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // the controller never asks for the zero bit and a data bit together
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dummy_i && bit_i));

endmodule

// File: rtl/srd_read_engine.sv
module srd_read_engine #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              rd_cmd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              do_dat_o
);
  import srd_pkg::*;

  localparam int unsigned RX_BITS = rx_len(ADDR_W);
  localparam int unsigned RXC_W   = $clog2(RX_BITS);
  localparam logic [RXC_W-1:0] RX_LAST = RXC_W'(RX_BITS - 1);

  rd_phase_e         phase_q;
  logic [RXC_W-1:0]  rx_cnt_q;
  logic [ADDR_W-1:0] word_addr_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [WORD_W-1:0] rd_word;
  logic              sk_rise;
  logic              dummy_stb;
  logic              bit_stb;
  logic              reload;
  logic              advance;

  srd_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sk_i   (sk_i),
    .rise_o (sk_rise)
  );

  srd_wordmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (word_addr_q),
    .rd_data_o (rd_word)
  );

  assign dummy_stb = cs_i && sk_rise && (phase_q == PH_DUMMY);
  assign bit_stb   = cs_i && sk_rise && (phase_q == PH_DATA);
  assign advance   = dummy_stb || reload;
  assign addr_nx   = ADDR_W'(wrap_inc(16'(word_addr_q), ADDR_W));

  srd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!cs_i),
    .dummy_i  (dummy_stb),
    .bit_i    (bit_stb),
    .word_i   (rd_word),
    .dout_o   (do_dat_o),
    .reload_o (reload)
  );

  // phase, address receive and word address counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      rx_cnt_q    <= '0;
      word_addr_q <= '0;
    end else if (!cs_i) begin
      phase_q  <= PH_IDLE;
      rx_cnt_q <= '0;
    end else if (advance) begin
      // the word after the one just loaded is fetched early
      word_addr_q <= addr_nx;
      if (dummy_stb) phase_q <= PH_DATA;
    end else if (sk_rise) begin
      unique case (phase_q)
        PH_IDLE: if (rd_cmd_i) begin
          phase_q  <= PH_ADDR;
          rx_cnt_q <= '0;
        end
        PH_ADDR: begin
          // a leading pad bit falls off the top of the register
          word_addr_q <= {word_addr_q[ADDR_W-2:0], di_i};
          if (rx_cnt_q == RX_LAST) phase_q <= PH_DUMMY;
          else                     rx_cnt_q <= rx_cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign do_oe_o = cs_i && (phase_q == PH_DATA);
  assign do_o    = do_oe_o ? do_dat_o : 1'bz;

  // deselect returns the engine to idle
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (phase_q == PH_IDLE));

  // the first bit seen with the driver on is the zero bit
  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe_o) |-> !do_dat_o);

  // a word boundary moves the fetch address one word up
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !(&word_addr_q)) |=> (word_addr_q == $past(word_addr_q) + 1'b1));

  // the top word is followed by word zero
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && (&word_addr_q)) |=> (word_addr_q == '0));

endmodule

// File: tb/srd_read_engine_tb.sv
module srd_read_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int WW = 16;
  localparam int NBITS_ADDR = 8;      // 7 address bits plus a leading pad bit
  localparam int NVEC = 4;
  // each entry: {start address[15:8], word count[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{16'h05_01, 16'h20_02, 16'h7E_03, 16'h3F_01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, rd_cmd = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic do_pin, do_oe, do_dat;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srd_read_engine #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .rd_cmd_i(rd_cmd),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .do_o(do_pin), .do_oe_o(do_oe), .do_dat_o(do_dat)
  );

  function automatic logic [WW-1:0] pattern(input int a);
    return 16'(a * 16'h0139) ^ 16'h5A3C ^ 16'(a << 9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one serial clock period; returns with SK low and outputs settled
  task automatic tick_sk();
    @(negedge clk); sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input int addr, input bit pad);
    logic [NBITS_ADDR-1:0] bits;
    bits = {pad, 7'(addr)};
    @(negedge clk); cs = 1'b1; rd_cmd = 1'b1;
    tick_sk();
    rd_cmd = 1'b0;
    for (int i = NBITS_ADDR - 1; i >= 0; i--) begin
      di = bits[i];
      tick_sk();
    end
  endtask

  task automatic get_word(output logic [WW-1:0] w);
    w = '0;
    for (int b = 0; b < WW; b++) begin
      tick_sk();
      w = {w[WW-2:0], do_dat};
    end
  endtask

  task automatic deselect();
    @(negedge clk); cs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic stream(input int addr, input int n);
    logic [WW-1:0] w;
    int a;
    send_cmd(addr, 1'b1);
    chk(do_oe == 1'b0, "R7 driver off in address phase", 32'(do_oe), 0);
    tick_sk();
    chk(do_oe && !do_dat, "R3 zero bit", {30'd0, do_oe, do_dat}, 32'h2);
    for (int k = 0; k < n; k++) begin
      a = (addr + k) % (1 << AW);
      get_word(w);
      if (k == 0)               chk(w == pattern(a), "R4 first word", 32'(w), 32'(pattern(a)));
      else if (addr + k >= 128) chk(w == pattern(a), "R6 wrapped word", 32'(w), 32'(pattern(a)));
      else                      chk(w == pattern(a), "R5 next word", 32'(w), 32'(pattern(a)));
    end
    deselect();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [WW-1:0] w1, w2;
    logic held;
    repeat (3) @(negedge clk);
    chk(do_oe == 1'b0 && do_dat == 1'b0, "R1 reset outputs", {30'd0, do_oe, do_dat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(do_oe == 1'b0 && do_dat == 1'b0, "R1 after reset", {30'd0, do_oe, do_dat}, 0);
    chk(do_pin === 1'bz, "R7 pin released", {31'd0, do_pin}, 0);

    for (int a = 0; a < (1 << AW); a++) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pattern(a);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // table walk
    for (int v = 0; v < NVEC; v++) stream(int'(VEC[v][15:8]), int'(VEC[v][7:0]));

    // R2: pad bit value has no effect on the word selected
    send_cmd(7'h2A, 1'b0); tick_sk(); get_word(w1); deselect();
    send_cmd(7'h2A, 1'b1); tick_sk(); get_word(w2); deselect();
    chk(w1 == pattern(7'h2A), "R2 pad 0", 32'(w1), 32'(pattern(7'h2A)));
    chk(w2 == w1, "R2 pad 1", 32'(w2), 32'(w1));

    // R7: select high but idle keeps the driver off
    @(negedge clk); cs = 1'b1;
    tick_sk();
    chk(do_oe == 1'b0, "R7 idle with select", 32'(do_oe), 0);
    deselect();

    // R8: hold the serial clock mid-word
    send_cmd(7'h11, 1'b1); tick_sk();
    for (int b = 0; b < 5; b++) tick_sk();
    held = do_dat;
    chk(held == pattern(7'h11)[11], "R4 bit order", 32'(held), 32'(pattern(7'h11)[11]));
    repeat (40) @(negedge clk);
    chk(do_dat == held && do_oe, "R8 held without clock", {30'd0, do_oe, do_dat}, {30'd0, 1'b1, held});

    // R7: abort mid-word then restart
    @(negedge clk); cs = 1'b0;
    #1;
    chk(do_oe == 1'b0, "R7 abort drops driver", 32'(do_oe), 0);
    chk(do_pin === 1'bz, "R7 abort releases pin", {31'd0, do_pin}, 0);
    repeat (2) @(negedge clk);
    send_cmd(7'h40, 1'b1);
    tick_sk();
    chk(do_oe && !do_dat, "R7 restart zero bit", {30'd0, do_oe, do_dat}, 32'h2);
    get_word(w1);
    chk(w1 == pattern(7'h40), "R7 restart word", 32'(w1), 32'(pattern(7'h40)));
    deselect();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule